// File: doc/BRIEF.md
# Flash Status Word and Suspend Controller

This block follows the life of one embedded program or erase operation inside a NOR flash model. It sits between a host command path and a simple operation engine. The host writes single-cycle command codes and issues reads. The engine reports when an operation starts and when it ends, and whether it failed or touched a locked sector. The block keeps an 8-bit status word. That word is handed out for exactly one read after a status-read command. Any other read returns the fixed array pattern.

Program and erase each have their own suspend and resume codes. A suspend raises `eng_hold` toward the engine at once. The status word keeps reporting busy for a fixed settling window of `LAT_CYCLES` clocks. This window stands for the minimum suspend latency. After it, the word reports either the suspended state or, if the engine finished during the window, the completed state.

States of the controller: `S_READY` (no operation), `S_PG_RUN` / `S_ER_RUN` (operation active), `S_PG_SETTLE` / `S_ER_SETTLE` (suspend latency counting), `S_PG_HELD` / `S_ER_HELD` (suspended). The transitions are:
- start: `S_READY` to a RUN state.
- finish: a RUN state to `S_READY`.
- suspend: RUN to SETTLE.
- settle-expire: SETTLE to HELD, or to `S_READY` if the operation finished during the window.
- resume: HELD to RUN.

Top module: `flash_stat_ctrl`

## Requirements
- R1: After reset the controller is in `S_READY`, `eng_hold` is 0, `rd_ack` is 0, no status read is armed, and a read returns `ARRAY_WORD` (default 16'hFFFF).
- R2: The status word occupies `rd_data[7:0]`, and `rd_data[15:8]` is 0. The bits are:
  - bit 7: 1 when ready.
  - bit 6: erase held.
  - bit 5: erase error.
  - bit 4: program failure.
  - bit 3: always 0.
  - bit 2: program held.
  - bit 1: locked-sector error.
  - bit 0: 1 when an active or held operation lies in the bank given with the status-read command. The bank is the top `BANK_W` bits of the sector number.
- R3: While bit 7 reads 0 (RUN or SETTLE state), bits 6 to 0 of the returned word are all 0.
- R4: Command 8'h70 arms one status read. The next read returns the status word and disarms. Later reads return `ARRAY_WORD` until 8'h70 is written again.
- R5: `rd_ack` is high in the cycle after each `rd_req` cycle, and `rd_data` is valid with it. The status word reflects the state just before the request edge.
- R6: `op_start` is accepted only in `S_READY`. It clears all three error bits and enters the RUN state selected by `op_erase`. In any other state it is ignored.
- R7: `op_done` ends the operation. With `op_fail` it sets bit 5 for an erase and bit 4 for a program. With `op_lock` it sets bit 1. The error bits stay set until the next accepted start.
- R8: Command 8'h51 during `S_PG_RUN`, or 8'hB0 during `S_ER_RUN`, raises `eng_hold` on the next cycle. Status reports busy for exactly `LAT_CYCLES` clocks and then reports ready with bit 2 (program) or bit 6 (erase) set.
- R9: If `op_done` arrives during a SETTLE state, it records its error flags. When the window expires, the controller goes to `S_READY` with no held bit set, and `eng_hold` drops.
- R10: Command 8'h50 in `S_PG_HELD`, or 8'h30 in `S_ER_HELD`, resumes the operation only when `cmd_sect` equals the operation's sector. The controller returns to RUN and `eng_hold` drops on the next cycle.
- R11: The following commands are ignored:
  - a suspend code whose matching operation is not running;
  - a resume code in any state other than the matching HELD state, or with a different sector;
  - any suspend or resume code during SETTLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| cmd_sect | input | SECT_W | Sector number carried by the command |
| rd_req | input | 1 | Read request, one cycle per read |
| rd_data | output | 16 | Read data, valid with rd_ack |
| rd_ack | output | 1 | Read response strobe |
| op_start | input | 1 | Engine starts an operation |
| op_erase | input | 1 | With op_start: 1 erase, 0 program |
| op_sect | input | SECT_W | With op_start: target sector |
| op_done | input | 1 | Engine finished the operation |
| op_fail | input | 1 | With op_done: operation failed |
| op_lock | input | 1 | With op_done: locked sector hit |
| eng_hold | output | 1 | Tells the engine to pause |

## Verification
State changes from a command or engine strobe take effect on the edge that samples the strobe. `eng_hold` therefore shows the new state one cycle after the stimulus. A read response appears one cycle after `rd_req` and carries the status as it stood before that edge. The settle window ends exactly `LAT_CYCLES` edges after the suspend edge.

The bench drives inputs on falling edges. A behavioural model advances on each rising edge, and the bench compares `eng_hold`, `rd_ack` and `rd_data` on the following falling edge. Directed reads then sample the response on the falling edge after the request, against literal expected words.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam logic [7:0] OP_PG_SUSP = 8'h51;
    localparam logic [7:0] OP_PG_RES  = 8'h50;
    localparam logic [7:0] OP_ER_SUSP = 8'hB0;
    localparam logic [7:0] OP_ER_RES  = 8'h30;

    typedef enum logic [2:0] {
        S_READY     = 3'd0,
        S_PG_RUN    = 3'd1,
        S_PG_SETTLE = 3'd2,
        S_PG_HELD   = 3'd3,
        S_ER_RUN    = 3'd4,
        S_ER_SETTLE = 3'd5,
        S_ER_HELD   = 3'd6
    } st_e;

    typedef struct packed {
        logic pg_susp;
        logic pg_res;
        logic er_susp;
        logic er_res;
        logic stat_arm;
    } cmd_s;

    typedef struct packed {
        logic er_err;
        logic pg_fail;
        logic lock_err;
    } err_s;

endpackage

// File: rtl/fsc_cmd_decode.sv
module fsc_cmd_decode
    import fsc_pkg::*;
#(
    parameter logic [7:0] STAT_OP = 8'h70
) (
    input  logic       cmd_we,
    input  logic [7:0] cmd_code,
    output cmd_s       cmd
);

    always_comb begin
        cmd          = '0;
        cmd.pg_susp  = cmd_we && (cmd_code == OP_PG_SUSP);
        cmd.pg_res   = cmd_we && (cmd_code == OP_PG_RES);
        cmd.er_susp  = cmd_we && (cmd_code == OP_ER_SUSP);
        cmd.er_res   = cmd_we && (cmd_code == OP_ER_RES);
        cmd.stat_arm = cmd_we && (cmd_code == STAT_OP);
    end

endmodule

// File: rtl/fsc_susp_fsm.sv
module fsc_susp_fsm
    import fsc_pkg::*;
#(
    parameter int SECT_W     = 8,
    parameter int LAT_CYCLES = 3750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_s              cmd,
    input  logic [SECT_W-1:0] cmd_sect,
    input  logic              op_start,
    input  logic              op_erase,
    input  logic [SECT_W-1:0] op_sect,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic              op_lock,
    output st_e               st,
    output err_s              err,
    output logic [SECT_W-1:0] act_sect,
    output logic              eng_hold
);

    localparam int CNT_W = $clog2(LAT_CYCLES + 1);
    localparam int AGE_W = CNT_W + 1;

    st_e               st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              fin, fin_nx;
    err_s              err_nx;
    logic [SECT_W-1:0] sect_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_READY;
            cnt      <= '0;
            fin      <= 1'b0;
            err      <= '0;
            act_sect <= '0;
        end else begin
            st       <= st_nx;
            cnt      <= cnt_nx;
            fin      <= fin_nx;
            err      <= err_nx;
            act_sect <= sect_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        fin_nx  = fin;
        err_nx  = err;
        sect_nx = act_sect;
        unique case (st)
            S_READY: begin
                if (op_start) begin
                    st_nx   = op_erase ? S_ER_RUN : S_PG_RUN;
                    sect_nx = op_sect;
                    err_nx  = '0;
                end
            end
            S_PG_RUN, S_ER_RUN: begin
                if (op_done) begin
                    st_nx = S_READY;
                    if (op_fail) begin
                        if (st == S_ER_RUN) err_nx.er_err  = 1'b1;
                        else                err_nx.pg_fail = 1'b1;
                    end
                    if (op_lock) err_nx.lock_err = 1'b1;
                end else if ((st == S_PG_RUN && cmd.pg_susp) ||
                             (st == S_ER_RUN && cmd.er_susp)) begin
                    st_nx  = (st == S_PG_RUN) ? S_PG_SETTLE : S_ER_SETTLE;
                    cnt_nx = CNT_W'(LAT_CYCLES - 1);
                    fin_nx = 1'b0;
                end
            end
            S_PG_SETTLE, S_ER_SETTLE: begin
                if (op_done) begin
                    fin_nx = 1'b1;
                    if (op_fail) begin
                        if (st == S_ER_SETTLE) err_nx.er_err  = 1'b1;
                        else                   err_nx.pg_fail = 1'b1;
                    end
                    if (op_lock) err_nx.lock_err = 1'b1;
                end
                if (cnt == '0) begin
                    if (fin || op_done) st_nx = S_READY;
                    else st_nx = (st == S_PG_SETTLE) ? S_PG_HELD : S_ER_HELD;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            S_PG_HELD: begin
                if (cmd.pg_res && cmd_sect == act_sect) st_nx = S_PG_RUN;
            end
            S_ER_HELD: begin
                if (cmd.er_res && cmd_sect == act_sect) st_nx = S_ER_RUN;
            end
            default: st_nx = S_READY;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st)
            S_PG_SETTLE, S_PG_HELD, S_ER_SETTLE, S_ER_HELD: eng_hold = 1'b1;
            default:                                         eng_hold = 1'b0;
        endcase
    end

    // settle-window age, kept apart from the down counter
    logic [AGE_W-1:0] lat_age;
    always_ff @(posedge clk) begin
        if (!rst_n) lat_age <= '0;
        else if (st == S_PG_SETTLE || st == S_ER_SETTLE) lat_age <= lat_age + 1'b1;
        else lat_age <= '0;
    end

    assert_pg_settle_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PG_HELD && $past(st) == S_PG_SETTLE) |-> lat_age == AGE_W'(LAT_CYCLES));

    assert_er_settle_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ER_HELD && $past(st) == S_ER_SETTLE) |-> lat_age == AGE_W'(LAT_CYCLES));

    assert_susp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PG_RUN && cmd.pg_susp && !op_done) |=> eng_hold);

    assert_idle_susp_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_READY && !op_start) |=> st == S_READY);

    assert_start_only_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PG_HELD && op_start && !cmd.pg_res) |=> st == S_PG_HELD);

    assert_resume_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ER_HELD && cmd.er_res && cmd_sect == act_sect) |=> !eng_hold);

endmodule

// File: rtl/fsc_status_port.sv
module fsc_status_port
    import fsc_pkg::*;
#(
    parameter int          SECT_W     = 8,
    parameter int          BANK_W     = 3,
    parameter logic [15:0] ARRAY_WORD = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_arm,
    input  logic [SECT_W-1:0] cmd_sect,
    input  logic              rd_req,
    input  st_e               st,
    input  err_s              err,
    input  logic [SECT_W-1:0] act_sect,
    output logic [15:0]       rd_data,
    output logic              rd_ack
);

    localparam int BANK_LSB = SECT_W - BANK_W;

    logic              armed;
    logic [BANK_W-1:0] arm_bank;
    logic [7:0]        stat_word;
    logic              is_ready;
    logic              was_stat;

    always_comb begin
        is_ready  = (st == S_READY) || (st == S_PG_HELD) || (st == S_ER_HELD);
        stat_word = '0;
        if (is_ready) begin
            stat_word[7] = 1'b1;
            stat_word[6] = (st == S_ER_HELD);
            stat_word[5] = err.er_err;
            stat_word[4] = err.pg_fail;
            stat_word[2] = (st == S_PG_HELD);
            stat_word[1] = err.lock_err;
            stat_word[0] = (st != S_READY) && (act_sect[SECT_W-1:BANK_LSB] == arm_bank);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            arm_bank <= '0;
            rd_data  <= '0;
            rd_ack   <= 1'b0;
            was_stat <= 1'b0;
        end else begin
            rd_ack   <= rd_req;
            was_stat <= rd_req && armed;
            if (rd_req) begin
                rd_data <= armed ? {8'h00, stat_word} : ARRAY_WORD;
                armed   <= 1'b0;
            end
            if (stat_arm) begin
                armed    <= 1'b1;
                arm_bank <= cmd_sect[SECT_W-1:BANK_LSB];
            end
        end
    end

    assert_ack_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_ack);

    assert_unarmed_array_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !armed) |=> rd_data == ARRAY_WORD);

    assert_busy_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && was_stat && !rd_data[7]) |-> rd_data[6:0] == 7'd0);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && was_stat) |-> (rd_data[15:8] == 8'd0 && !rd_data[3]));

endmodule

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
    import fsc_pkg::*;
#(
    parameter int          SECT_W     = 8,
    parameter int          BANK_W     = 3,
    parameter int          LAT_CYCLES = 3750,
    parameter logic [7:0]  STAT_OP    = 8'h70,
    parameter logic [15:0] ARRAY_WORD = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_code,
    input  logic [SECT_W-1:0] cmd_sect,
    input  logic              rd_req,
    output logic [15:0]       rd_data,
    output logic              rd_ack,
    input  logic              op_start,
    input  logic              op_erase,
    input  logic [SECT_W-1:0] op_sect,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic              op_lock,
    output logic              eng_hold
);

    cmd_s              cmd;
    st_e               st;
    err_s              err;
    logic [SECT_W-1:0] act_sect;

    fsc_cmd_decode #(.STAT_OP(STAT_OP)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_code (cmd_code),
        .cmd      (cmd)
    );

    fsc_susp_fsm #(.SECT_W(SECT_W), .LAT_CYCLES(LAT_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .cmd_sect (cmd_sect),
        .op_start (op_start),
        .op_erase (op_erase),
        .op_sect  (op_sect),
        .op_done  (op_done),
        .op_fail  (op_fail),
        .op_lock  (op_lock),
        .st       (st),
        .err      (err),
        .act_sect (act_sect),
        .eng_hold (eng_hold)
    );

    fsc_status_port #(.SECT_W(SECT_W), .BANK_W(BANK_W), .ARRAY_WORD(ARRAY_WORD)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_arm (cmd.stat_arm),
        .cmd_sect (cmd_sect),
        .rd_req   (rd_req),
        .st       (st),
        .err      (err),
        .act_sect (act_sect),
        .rd_data  (rd_data),
        .rd_ack   (rd_ack)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!eng_hold && !rd_ack));

endmodule

// File: tb/tb_flash_stat_ctrl.sv
module tb_flash_stat_ctrl;

    localparam int SECT_W = 8;
    localparam int BANK_W = 3;
    localparam int LAT    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_we = 1'b0;
    logic [7:0]        cmd_code = '0;
    logic [SECT_W-1:0] cmd_sect = '0;
    logic              rd_req = 1'b0;
    logic [15:0]       rd_data;
    logic              rd_ack;
    logic              op_start = 1'b0, op_erase = 1'b0, op_done = 1'b0;
    logic              op_fail = 1'b0, op_lock = 1'b0;
    logic [SECT_W-1:0] op_sect = '0;
    logic              eng_hold;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_stat_ctrl #(.SECT_W(SECT_W), .BANK_W(BANK_W), .LAT_CYCLES(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .cmd_sect(cmd_sect), .rd_req(rd_req), .rd_data(rd_data), .rd_ack(rd_ack),
        .op_start(op_start), .op_erase(op_erase), .op_sect(op_sect),
        .op_done(op_done), .op_fail(op_fail), .op_lock(op_lock), .eng_hold(eng_hold)
    );

    // behavioural reference: mode 0 idle, 1/4 running, 2/5 settling, 3/6 held
    int        m_mode = 0, m_left = 0, m_opsec = 0, m_armsec = 0;
    bit        m_fin = 0, m_eer = 0, m_epg = 0, m_elk = 0, m_armed = 0;
    bit        x_ack = 0, x_hold = 0;
    bit [15:0] x_data = 0;

    function automatic bit [15:0] m_status();
        bit [15:0] w = 0;
        if (m_mode == 0 || m_mode == 3 || m_mode == 6) begin
            w[7] = 1; w[6] = (m_mode == 6); w[5] = m_eer; w[4] = m_epg;
            w[2] = (m_mode == 3); w[1] = m_elk;
            w[0] = (m_mode != 0) && ((m_opsec >> (SECT_W-BANK_W)) == (m_armsec >> (SECT_W-BANK_W)));
        end
        return w;
    endfunction

    task automatic m_record(bit erase_op);
        if (op_fail) begin
            if (erase_op) m_eer = 1; else m_epg = 1;
        end
        if (op_lock) m_elk = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_armed = 0; m_eer = 0; m_epg = 0; m_elk = 0;
            x_ack = 0; x_data = 0; x_hold = 0;
        end else begin
            x_ack = rd_req;
            if (rd_req) begin
                x_data = m_armed ? m_status() : 16'hFFFF;
                m_armed = 0;
            end
            if (cmd_we && cmd_code == 8'h70) begin m_armed = 1; m_armsec = int'(cmd_sect); end
            case (m_mode)
                0: if (op_start) begin
                       m_mode = op_erase ? 4 : 1; m_opsec = int'(op_sect);
                       m_eer = 0; m_epg = 0; m_elk = 0;
                   end
                1, 4: if (op_done) begin
                       m_record(m_mode == 4); m_mode = 0;
                   end else if (cmd_we && ((m_mode == 1 && cmd_code == 8'h51) ||
                                           (m_mode == 4 && cmd_code == 8'hB0))) begin
                       m_mode = m_mode + 1; m_left = LAT; m_fin = 0;
                   end
                2, 5: begin
                       if (op_done) begin m_record(m_mode == 5); m_fin = 1; end
                       m_left = m_left - 1;
                       if (m_left == 0) m_mode = m_fin ? 0 : m_mode + 1;
                   end
                3: if (cmd_we && cmd_code == 8'h50 && int'(cmd_sect) == m_opsec) m_mode = 1;
                6: if (cmd_we && cmd_code == 8'h30 && int'(cmd_sect) == m_opsec) m_mode = 4;
                default: m_mode = 0;
            endcase
            x_hold = (m_mode == 2 || m_mode == 3 || m_mode == 5 || m_mode == 6);
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (eng_hold !== x_hold) begin
                errors++;
                $display("FAIL R8 eng_hold act=%0b exp=%0b t=%0t", eng_hold, x_hold, $time);
            end
            checks++;
            if (rd_ack !== x_ack) begin
                errors++;
                $display("FAIL R5 rd_ack act=%0b exp=%0b t=%0t", rd_ack, x_ack, $time);
            end
            if (x_ack) begin
                checks++;
                if (rd_data !== x_data) begin
                    errors++;
                    $display("FAIL R2 rd_data act=%h exp=%h t=%0t", rd_data, x_data, $time);
                end
            end
        end
    end

    task automatic expect_eq(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send(logic [7:0] code, logic [SECT_W-1:0] sect);
        cmd_we = 1; cmd_code = code; cmd_sect = sect;
        @(negedge clk);
        cmd_we = 0; cmd_code = '0; cmd_sect = '0;
    endtask

    task automatic do_read(string tag, logic [15:0] exp);
        rd_req = 1;
        @(negedge clk);
        rd_req = 0;
        expect_eq(tag, rd_data, exp);
    endtask

    task automatic stat_read(string tag, logic [SECT_W-1:0] sect, logic [15:0] exp);
        send(8'h70, sect);
        do_read(tag, exp);
    endtask

    task automatic start_op(bit erase, logic [SECT_W-1:0] sect);
        op_start = 1; op_erase = erase; op_sect = sect;
        @(negedge clk);
        op_start = 0; op_erase = 0; op_sect = '0;
    endtask

    task automatic finish_op(bit fail, bit lock);
        op_done = 1; op_fail = fail; op_lock = lock;
        @(negedge clk);
        op_done = 0; op_fail = 0; op_lock = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_eq("R1 hold after reset", {15'd0, eng_hold}, 16'd0);
        expect_eq("R1 ack after reset", {15'd0, rd_ack}, 16'd0);
        do_read("R1 unarmed read", 16'hFFFF);
        // R2 / R4 idle status then one-shot
        stat_read("R2 idle status", 8'h00, 16'h0080);
        do_read("R4 second read array", 16'hFFFF);
        // R3 busy program
        start_op(0, 8'h25);
        stat_read("R3 busy word", 8'h20, 16'h0000);
        // R8 program suspend
        send(8'h51, 8'h00);
        expect_eq("R8 hold raised", {15'd0, eng_hold}, 16'd1);
        stat_read("R8 settling still busy", 8'h20, 16'h0000);
        repeat (LAT) @(negedge clk);
        stat_read("R8 program held same bank", 8'h20, 16'h0085);
        stat_read("R2 program held other bank", 8'hE0, 16'h0084);
        // R11 mismatched suspend ignored
        send(8'hB0, 8'h00);
        stat_read("R11 erase suspend ignored", 8'hE0, 16'h0084);
        // R6 start ignored while held
        start_op(1, 8'h60);
        stat_read("R6 start ignored in held", 8'hE0, 16'h0084);
        // R10 resume with wrong sector then right sector
        send(8'h50, 8'h26);
        stat_read("R10 wrong sector ignored", 8'hE0, 16'h0084);
        send(8'h50, 8'h25);
        expect_eq("R10 hold dropped", {15'd0, eng_hold}, 16'd0);
        stat_read("R10 resumed busy", 8'h20, 16'h0000);
        // R7 program failure sticky
        finish_op(1, 0);
        stat_read("R7 program fail", 8'h00, 16'h0090);
        stat_read("R7 fail still set", 8'h00, 16'h0090);
        // R11 suspend with idle, R6 start clears errors
        send(8'h51, 8'h00);
        expect_eq("R11 idle suspend no hold", {15'd0, eng_hold}, 16'd0);
        start_op(1, 8'h40);
        send(8'h51, 8'h00);
        expect_eq("R11 program suspend during erase", {15'd0, eng_hold}, 16'd0);
        // R9 done during settle
        send(8'hB0, 8'h00);
        repeat (4) @(negedge clk);
        send(8'h30, 8'h40);
        expect_eq("R11 resume during settle keeps hold", {15'd0, eng_hold}, 16'd1);
        finish_op(0, 1);
        repeat (LAT) @(negedge clk);
        expect_eq("R9 hold released", {15'd0, eng_hold}, 16'd0);
        stat_read("R9 completed with lock error", 8'h40, 16'h0082);
        // R8 erase held, R10 erase resume, R7 erase error
        start_op(1, 8'h41);
        send(8'hB0, 8'h00);
        repeat (LAT) @(negedge clk);
        stat_read("R8 erase held", 8'h40, 16'h00C1);
        send(8'h30, 8'h41);
        stat_read("R10 erase resumed busy", 8'h40, 16'h0000);
        finish_op(1, 0);
        stat_read("R7 erase error", 8'h40, 16'h00A0);
        do_read("R4 after status read", 16'hFFFF);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule